// File: doc/BRIEF.md
# Serial ADC Conversion and Read Controller

This block sits on the host side of a 16-bit successive-approximation converter that has a serial result output. A one-cycle pulse on `start_i` begins one complete cycle. The controller drops chip select and read/convert together for one system clock to start a conversion. It then releases both lines and waits for the converter's busy line to go low and then return high. After that it reads the result. The read uses a data clock divided from the system clock. That clock runs the whole time, including while chip select is high, so the converter is always armed to emit a sync marker when the read window opens.

The read window opens on a data-clock falling edge. Chip select goes low and read/convert stays high. The controller samples the sync line on each data-clock rising edge. Once it sees sync, it takes the next sixteen rising edges as result bits, most significant bit first. The word appears on `result_o` with a one-cycle `valid_o` strobe, and the controller returns to idle.

Two faults end a cycle with a one-cycle `err_o` strobe and a return to idle. The first is busy not completing its low-then-high sequence within a set number of system clocks. The second is no sync marker within a set number of data-clock rising edges.

Top module: `adc_serial_reader`

## Requirements
- R1: While reset is applied and after it is released, `cs_n_o` and `rc_o` are 1, and `valid_o`, `err_o` and `result_o` are 0.
- R2: A `start_i` pulse in idle drives `cs_n_o`=0 and `rc_o`=0 for exactly one system clock. In the next clock both return to 1. `rc_o` is never 0 while `cs_n_o` is 1.
- R3: The read window (`cs_n_o`=0 with `rc_o`=1) opens only after busy has been seen low and then high again.
- R4: `dclk_o` runs continuously in every state, with a period of 2*HALF_DIV system clocks.
- R5: The read window opens on a system clock where `dclk_o` has just fallen, so `dclk_o` is 0 when chip select goes low for the read.
- R6: Sync and data are sampled on `dclk_o` rising edges. The first data bit is taken at the rising edge after the one where sync was seen high. Sixteen bits are taken MSB first, and the last one is the LSB.
- R7: A good read gives exactly one one-cycle `valid_o` strobe with the word on `result_o`, and the controller is back in idle (`cs_n_o`=1) in that same cycle. `result_o` then holds the word until the next good read.
- R8: If sync is not seen within SYNC_WIN rising edges of the read window, the controller gives a one-cycle `err_o` with no `valid_o` and returns to idle. A later cycle then works normally.
- R9: If busy has not gone low and back high within BUSY_TMO system clocks of entering the busy wait, the controller gives a one-cycle `err_o` and returns to idle with `cs_n_o`=1 and `rc_o`=1.
- R10: `start_i` has no effect while a cycle is in progress. Each accepted start gives exactly one outcome, either `valid_o` or `err_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Pulse to begin one conversion-and-read cycle |
| busy_i | input | 1 | Converter busy flag, low during conversion |
| sync_i | input | 1 | Converter sync marker preceding the data |
| sdata_i | input | 1 | Converter serial result bit |
| cs_n_o | output | 1 | Chip select, active low |
| rc_o | output | 1 | Read/convert: 0 starts a conversion, 1 reads |
| dclk_o | output | 1 | Free-running divided data clock |
| result_o | output | DATA_W | Last good result word |
| valid_o | output | 1 | One-cycle strobe for a new result |
| err_o | output | 1 | One-cycle strobe for a timeout or a missing sync |

## Verification
The assertions assume that `start_i` is a single-cycle pulse. They also assume that the converter changes sync and data only after a data-clock rising edge, and that it keeps busy high for the whole read window. The bench's converter model meets these assumptions by construction. It updates its outputs half a system clock after it sees `dclk_o` rise, and it drops busy only in response to the convert pulse. The bench also gives the model fault modes: busy stuck high, busy stuck low, and a suppressed sync marker. With these modes the error paths are exercised while every input stays within those assumptions.

// File: rtl/adcrd_pkg.sv
// Shared types for the serial ADC read controller.
package adcrd_pkg;
    // Sequencer states, from idle through the conversion, the busy wait and the read.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CONV  = 3'd1,
        ST_BUSY  = 3'd2,
        ST_ALIGN = 3'd3,
        ST_SYNC  = 3'd4,
        ST_SHIFT = 3'd5
    } rd_state_e;
endpackage

// File: rtl/adcrd_clkdiv.sv
// Free-running data clock divider.
// dclk_o toggles once every HALF_DIV system clocks.
// rise_o and fall_o mark the system clock edge at which dclk_o goes high or low.
// Assumes HALF_DIV >= 1.
module adcrd_clkdiv #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic dclk_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick   = (cnt == LAST);
    assign rise_o = tick & ~dclk_o;
    assign fall_o = tick &  dclk_o;

    // Count system clocks and toggle the data clock at the end of each half period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            dclk_o <= 1'b0;
        end else if (tick) begin
            cnt    <= '0;
            dclk_o <= ~dclk_o;
        end else begin
            cnt    <= cnt + 1'b1;
        end
    end

    // R4: the data clock holds its level between divider ticks.
    assert_dclk_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(dclk_o));
endmodule

// File: rtl/adcrd_shifter.sv
// Serial-to-parallel shifter, MSB first.
// clear_i restarts the bit count. Each sample_i takes one bit.
// done_o pulses for one cycle once DATA_W bits are in word_o.
module adcrd_shifter #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              sample_i,
    input  logic              din_i,
    output logic [DATA_W-1:0] word_o,
    output logic              done_o
);
    localparam int BW = $clog2(DATA_W);
    localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

    logic [BW-1:0] bit_cnt;

    // Shift in one bit per sample and flag the final one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o  <= '0;
            bit_cnt <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (clear_i) begin
                bit_cnt <= '0;
            end else if (sample_i) begin
                word_o  <= {word_o[DATA_W-2:0], din_i};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == LAST_BIT) begin
                    done_o  <= 1'b1;
                    bit_cnt <= '0;
                end
            end
        end
    end

    // R6: a finished word is not sampled again in its done cycle.
    assert_no_sample_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !sample_i);
endmodule

// File: rtl/adcrd_sequencer.sv
// Conversion and read sequencer.
// Runs idle -> convert pulse -> busy wait -> align to a falling data clock edge
// -> sync search -> shift.
// A timeout or a missing sync ends the cycle with err_o.
// Assumes busy_i and sync_i are already synchronous to clk.
module adcrd_sequencer
    import adcrd_pkg::*;
#(
    parameter int BUSY_TMO = 64,
    parameter int SYNC_WIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic busy_i,
    input  logic sync_i,
    input  logic rise_i,
    input  logic fall_i,
    input  logic dclk_i,
    input  logic done_i,
    output logic cs_n_o,
    output logic rc_o,
    output logic clear_o,
    output logic sample_o,
    output logic err_o
);
    localparam int TW = $clog2(BUSY_TMO + 1);
    localparam int WW = (SYNC_WIN > 1) ? $clog2(SYNC_WIN) : 1;
    localparam logic [TW-1:0] TMO_LAST = TW'(BUSY_TMO - 1);
    localparam logic [WW-1:0] WIN_LAST = WW'(SYNC_WIN - 1);

    rd_state_e     state;
    logic [TW-1:0] tmo_cnt;
    logic [WW-1:0] win_cnt;
    logic          seen_low;

    // Decode the converter control lines and the shifter controls from the state.
    always_comb begin
        cs_n_o   = (state == ST_IDLE) || (state == ST_BUSY) || (state == ST_ALIGN);
        rc_o     = (state != ST_CONV);
        clear_o  = (state == ST_SYNC);
        sample_o = (state == ST_SHIFT) && rise_i && !done_i;
    end

    // Move between states and keep the timeout and sync-window counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            tmo_cnt  <= '0;
            win_cnt  <= '0;
            seen_low <= 1'b0;
            err_o    <= 1'b0;
        end else begin
            err_o <= 1'b0;
            unique case (state)
                ST_IDLE: if (start_i) state <= ST_CONV;
                ST_CONV: begin
                    state    <= ST_BUSY;
                    tmo_cnt  <= '0;
                    seen_low <= 1'b0;
                end
                ST_BUSY: begin
                    if (seen_low && busy_i) begin
                        state <= ST_ALIGN;
                    end else if (tmo_cnt == TMO_LAST) begin
                        state <= ST_IDLE;
                        err_o <= 1'b1;
                    end else begin
                        tmo_cnt <= tmo_cnt + 1'b1;
                        if (!busy_i) seen_low <= 1'b1;
                    end
                end
                ST_ALIGN: if (fall_i) begin
                    state   <= ST_SYNC;
                    win_cnt <= '0;
                end
                ST_SYNC: if (rise_i) begin
                    if (sync_i) begin
                        state <= ST_SHIFT;
                    end else if (win_cnt == WIN_LAST) begin
                        state <= ST_IDLE;
                        err_o <= 1'b1;
                    end else begin
                        win_cnt <= win_cnt + 1'b1;
                    end
                end
                ST_SHIFT: if (done_i) state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // R2: a conversion request only happens with chip select low.
    assert_convert_under_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rc_o |-> !cs_n_o);
    // R5: the read window opens with the data clock low.
    assert_read_opens_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SYNC && $past(state) == ST_ALIGN) |-> !dclk_i);
    // R3: the read window follows a busy high level.
    assert_read_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ALIGN && $past(state) == ST_BUSY) |-> $past(busy_i));
endmodule

// File: rtl/adc_serial_reader.sv
// Top level of the serial ADC conversion and read controller.
// Combines the data clock divider, the sequencer and the shifter.
// Registers the result word and the valid strobe.
// Assumes start_i is a single-cycle pulse and that the converter updates sync and data
// after data clock rising edges.
module adc_serial_reader
    import adcrd_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int HALF_DIV = 2,
    parameter int BUSY_TMO = 64,
    parameter int SYNC_WIN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              busy_i,
    input  logic              sync_i,
    input  logic              sdata_i,
    output logic              cs_n_o,
    output logic              rc_o,
    output logic              dclk_o,
    output logic [DATA_W-1:0] result_o,
    output logic              valid_o,
    output logic              err_o
);
    logic              rise, fall, clear, sample, done;
    logic [DATA_W-1:0] word;

    adcrd_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .dclk_o(dclk_o), .rise_o(rise), .fall_o(fall)
    );

    adcrd_sequencer #(.BUSY_TMO(BUSY_TMO), .SYNC_WIN(SYNC_WIN)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_i(busy_i), .sync_i(sync_i),
        .rise_i(rise), .fall_i(fall), .dclk_i(dclk_o), .done_i(done),
        .cs_n_o(cs_n_o), .rc_o(rc_o), .clear_o(clear), .sample_o(sample), .err_o(err_o)
    );

    adcrd_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clear_i(clear), .sample_i(sample), .din_i(sdata_i),
        .word_o(word), .done_o(done)
    );

    // Capture the finished word and raise the one-cycle valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= done;
            if (done) result_o <= word;
        end
    end

    // R7: valid lasts one cycle and finds the controller back in idle.
    assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    assert_valid_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> cs_n_o);
    // R8: a cycle never ends with both outcomes.
    assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && err_o));
    // R9: an error leaves both converter lines released.
    assert_err_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (cs_n_o && rc_o));
    // R7: the result only changes together with a valid strobe.
    assert_result_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(result_o));
endmodule

// File: tb/adc_serial_reader_tb.sv
// Scoreboard bench: the driver pushes expected outcomes, the monitor pops and compares them.
module adc_serial_reader_tb;
    localparam int DATA_W   = 16;
    localparam int HALF_DIV = 2;
    localparam int BUSY_TMO = 64;
    localparam int SYNC_WIN = 4;
    localparam int CONV_LEN = 10;

    typedef enum int {B_NORMAL, B_STUCK_HIGH, B_STUCK_LOW} bmode_e;
    typedef struct {
        bit          is_err;
        logic [15:0] word;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic busy_m, sync_m, sd_m;
    logic cs_n_o, rc_o, dclk_o, valid_o, err_o;
    logic [DATA_W-1:0] result_o;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    exp_t q[$];

    // Converter model configuration.
    bmode_e      cfg_bmode = B_NORMAL;
    bit          cfg_sync = 1;
    logic [15:0] cfg_word = '0;

    always #10 clk = ~clk;

    adc_serial_reader #(.DATA_W(DATA_W), .HALF_DIV(HALF_DIV), .BUSY_TMO(BUSY_TMO),
                        .SYNC_WIN(SYNC_WIN)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .busy_i(busy_m), .sync_i(sync_m),
        .sdata_i(sd_m), .cs_n_o(cs_n_o), .rc_o(rc_o), .dclk_o(dclk_o),
        .result_o(result_o), .valid_o(valid_o), .err_o(err_o)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Converter model: reacts half a system clock after each DUT edge.
    int  n = 0;
    bit  armed = 0;
    int  conv_left = 0;
    logic prev_dclk = 1'b0;
    logic prev_cs = 1'b1;
    always @(negedge clk) begin
        if (!rst_n) begin
            busy_m = 1'b1; sync_m = 1'b0; sd_m = 1'b0;
            armed = 0; n = 0; conv_left = 0; prev_dclk = 1'b0; prev_cs = 1'b1;
        end else begin
            if (!cs_n_o && !rc_o) begin
                if (cfg_bmode != B_STUCK_HIGH) busy_m = 1'b0;
                conv_left = CONV_LEN;
            end else if (!busy_m && cfg_bmode == B_NORMAL) begin
                if (conv_left <= 1) busy_m = 1'b1;
                else conv_left--;
            end
            if (prev_cs && !cs_n_o && rc_o) begin
                check(busy_m == 1'b1, "R3 read opened before busy returned", busy_m, 1);
                check(dclk_o == 1'b0, "R5 read opened with dclk high", dclk_o, 0);
            end
            if (dclk_o && !prev_dclk) begin
                if (cs_n_o || !rc_o) begin
                    armed = 1; n = 0; sync_m = 1'b0;
                end else if (armed) begin
                    n++;
                    if (n == 1) sync_m = cfg_sync;
                    else if (n == 2) begin sync_m = 1'b0; sd_m = cfg_word[15]; end
                    else if (n <= 17) sd_m = cfg_word[17-n];
                end
            end
            prev_dclk = dclk_o;
            prev_cs = cs_n_o;
        end
    end

    // Monitor: pop an expected outcome for every valid or error strobe.
    logic prev_valid = 1'b0;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (valid_o && prev_valid) check(0, "R7 valid longer than one cycle", 1, 0);
            if (valid_o || err_o) begin
                check(cs_n_o == 1'b1, "R7 outcome outside idle", cs_n_o, 1);
                if (q.size() == 0) begin
                    check(0, "R10 outcome with no accepted start", {valid_o, err_o}, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (e.is_err)
                        check(err_o && !valid_o, "R8/R9 expected error strobe",
                              {valid_o, err_o}, 1);
                    else
                        check(valid_o && !err_o && result_o == e.word, "R6 result word",
                              {err_o, valid_o, result_o}, {2'b01, e.word});
                end
            end
            prev_valid = valid_o;
        end
    end

    // Wait until the scoreboard has drained, with a bound.
    task automatic wait_drain();
        for (int i = 0; i < 3000 && q.size() != 0; i++) @(negedge clk);
        check(q.size() == 0, "R10 outcome missing", q.size(), 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic run_txn(input logic [15:0] w, input bmode_e bm, input bit sy,
                           input bit is_err);
        exp_t e;
        cfg_word = w; cfg_bmode = bm; cfg_sync = sy;
        e.is_err = is_err; e.word = w;
        q.push_back(e);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        wait_drain();
    endtask

    initial begin
        #3_000_000;
        if (!finished) begin
            finished = 1;
            fails++; checks++;
            $display("FAIL watchdog actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int per;
        int lat;
        repeat (4) @(negedge clk);
        // R1 state during reset
        check(cs_n_o && rc_o && !valid_o && !err_o && result_o == 0, "R1 reset state",
              {cs_n_o, rc_o, valid_o, err_o, result_o}, {4'b1100, 16'h0});
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_n_o && rc_o && !valid_o && !err_o && result_o == 0, "R1 after release",
              {cs_n_o, rc_o, valid_o, err_o, result_o}, {4'b1100, 16'h0});

        // R4 data clock period while idle
        while (dclk_o) @(negedge clk);
        while (!dclk_o) @(negedge clk);
        per = 0;
        do begin @(negedge clk); per++; end while (dclk_o);
        while (!dclk_o) begin @(negedge clk); per++; end
        check(per == 2 * HALF_DIV, "R4 dclk period", per, 2 * HALF_DIV);

        // R2 convert pulse shape, then the full read of a first word
        begin
            exp_t e;
            cfg_word = 16'hA5C3; cfg_bmode = B_NORMAL; cfg_sync = 1;
            e.is_err = 0; e.word = 16'hA5C3;
            q.push_back(e);
            @(negedge clk) start = 1'b1;
            @(negedge clk) start = 1'b0;
            check(!cs_n_o && !rc_o, "R2 convert pulse", {cs_n_o, rc_o}, 0);
            @(negedge clk);
            check(cs_n_o && rc_o, "R2 lines released after one clock", {cs_n_o, rc_o}, 3);
            wait_drain();
        end

        // R6 several bit patterns, including the edges of the range
        run_txn(16'h0000, B_NORMAL, 1, 0);
        run_txn(16'hFFFF, B_NORMAL, 1, 0);
        run_txn(16'h8001, B_NORMAL, 1, 0);
        run_txn(16'h1234, B_NORMAL, 1, 0);

        // R7 the result holds after the strobe
        repeat (30) @(negedge clk);
        check(result_o == 16'h1234 && !valid_o, "R7 result held", result_o, 16'h1234);

        // R8 missing sync gives an error, then a normal read works again
        run_txn(16'h5A5A, B_NORMAL, 0, 1);
        check(result_o == 16'h1234, "R8 result untouched by error", result_o, 16'h1234);
        run_txn(16'hC0DE, B_NORMAL, 1, 0);

        // R9 busy never falls: measure the timeout latency
        begin
            exp_t e;
            cfg_bmode = B_STUCK_HIGH; cfg_sync = 1;
            e.is_err = 1; e.word = 0;
            q.push_back(e);
            @(negedge clk) start = 1'b1;
            @(negedge clk) start = 1'b0;
            lat = 1;
            while (!err_o && lat < 1000) begin @(negedge clk); lat++; end
            check(lat >= BUSY_TMO && lat <= BUSY_TMO + 3, "R9 timeout latency", lat,
                  BUSY_TMO + 2);
            wait_drain();
        end
        // R9 busy never returns high
        run_txn(16'h0F0F, B_STUCK_LOW, 1, 1);
        run_txn(16'h3C3C, B_NORMAL, 1, 0);

        // R10 extra start pulses during a cycle are ignored
        begin
            exp_t e;
            int lows;
            cfg_word = 16'h7E81; cfg_bmode = B_NORMAL; cfg_sync = 1;
            e.is_err = 0; e.word = 16'h7E81;
            q.push_back(e);
            @(negedge clk) start = 1'b1;
            @(negedge clk) start = 1'b0;
            repeat (5) @(negedge clk);
            start = 1'b1; @(negedge clk); start = 1'b0;
            repeat (30) @(negedge clk);
            start = 1'b1; @(negedge clk); start = 1'b0;
            wait_drain();
            lows = 0;
            for (int i = 0; i < 60; i++) begin
                @(negedge clk);
                if (!cs_n_o) lows++;
            end
            check(lows == 0, "R10 ignored start began a cycle", lows, 0);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule